// File: doc/BRIEF.md
# Cascadable Prescaled Timer Bank

This block holds four 16-bit up-counters for a single processor. Each counter has a reload register and a small control register, and software reaches all of them through a plain write port and a combinational read port. A counter advances in one of two ways. It can advance on a prescaled version of the shared base tick. It can also be chained, and then it advances only when the counter below it overflows. When a counter passes 0xFFFF it takes the reload value instead of zero. It can raise a one-cycle interrupt pulse, and it can advance the chained counter above it.

A write carries a 16-bit data word. Bit 0 of the address picks the field: 0 is reload and 1 is control. The upper address bits pick the timer. A read returns the control field in the upper half of a 32-bit word and the live counter in the lower half. No data streams through the block, so every pin is a plain strobe or level. The block has no valid/ready handshake and never applies back-pressure, and each write takes effect in the clock cycle it is presented. Within one clock cycle, an overflow passes up through every chained timer that is enabled.

Top module: `chain_timer_bank`

## Requirements
- R1: After reset every counter, reload, control field and interrupt output is zero.
- R2: A read of timer n returns control in bits [31:16] and the counter in bits [15:0]. Control keeps only start (bit 7), interrupt enable (bit 6), chain mode (bit 2) and prescale select (bits 1:0). All other control bits read as zero.
- R3: A control write that moves start from 0 to 1 copies the reload value into the counter and clears that timer's prescale divider. A control write that leaves start at 1 does not reload the counter.
- R4: While start is 0 the counter holds its value.
- R5: In prescaled mode a running counter advances once every 1, 64, 256 or 1024 base ticks, for select values 0, 1, 2 and 3. The first advance comes one full period after start. Clock cycles without a tick do not count.
- R6: When a counter advances from 0xFFFF it loads the reload value instead of 0.
- R7: An overflow with interrupt enable set raises that timer's irq bit for exactly one cycle. The pulse appears in the same cycle that the counter shows the reloaded value. An overflow with interrupt enable clear raises nothing.
- R8: A timer in chain mode ignores base ticks and advances only when the timer below it overflows.
- R9: An overflow advances timer n+1 only when that timer has both start and chain mode set. A whole cascade of overflows updates all affected counters in the same cycle.
- R10: Timer 0 in chain mode never advances. An overflow of timer 3 affects no other timer.
- R11: Writing the reload register does not change a running counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Base count tick, one cycle per tick |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 3 | [2:1] timer index, [0] field: 0 reload, 1 control |
| bus_wdata | input | 16 | Write data |
| rd_sel | input | 2 | Timer index for the read port |
| rd_data | output | 32 | {control, counter} of the selected timer |
| irq | output | 4 | One-cycle overflow interrupt pulse per timer |

## Verification
The checker watches four things on every cycle. It checks that a stopped counter holds, that a chained counter moves only after the timer below it overflows, and that timer 0 in chain mode stays still. It also checks that every interrupt pulse follows an enabled overflow and leaves the counter at the previous reload value. Only the bench scenarios can show the exact prescale periods, the readback format, the reload-on-start rule against a repeated start write, and the timing of a full cascade within a single tick.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  localparam int DIV_W = 10;

  typedef struct packed {
    logic       start;
    logic       ien;
    logic       casc;
    logic [1:0] psel;
  } tmr_ctrl_t;

  // terminal divider value for each prescale select
  function automatic logic [DIV_W-1:0] div_last(input logic [1:0] psel);
    case (psel)
      2'd0:    div_last = DIV_W'(0);
      2'd1:    div_last = DIV_W'(63);
      2'd2:    div_last = DIV_W'(255);
      default: div_last = DIV_W'(1023);
    endcase
  endfunction
endpackage

// File: rtl/tmr_prescaler.sv
`timescale 1ns/1ps
module tmr_prescaler
  import tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       en,
  input  logic       tick,
  input  logic [1:0] psel,
  output logic       hit
);
  logic [DIV_W-1:0] div_q;

  assign hit = en && tick && (div_q == div_last(psel));

  always_ff @(posedge clk) begin
    if (!rst_n)          div_q <= '0;
    else if (clr)        div_q <= '0;
    else if (hit)        div_q <= '0;
    else if (en && tick) div_q <= div_q + DIV_W'(1);
  end
endmodule

// File: rtl/tmr_channel.sv
`timescale 1ns/1ps
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_reload,
  input  logic             wr_ctrl,
  input  logic [CNT_W-1:0] wdata,
  input  logic             chain_in,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] reload_o,
  output tmr_ctrl_t        ctrl_o,
  output logic             ovf_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] cnt_q, reload_q;
  tmr_ctrl_t        ctrl_q;
  logic             start_edge, hit, inc;

  assign start_edge = wr_ctrl && wdata[7] && !ctrl_q.start;
  assign inc        = ctrl_q.start && (ctrl_q.casc ? chain_in : hit);
  assign ovf_o      = inc && (cnt_q == {CNT_W{1'b1}});

  tmr_prescaler u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (start_edge),
    .en   (ctrl_q.start && !ctrl_q.casc),
    .tick (tick),
    .psel (ctrl_q.psel),
    .hit  (hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      reload_q <= '0;
      ctrl_q   <= '0;
      irq_o    <= 1'b0;
    end else begin
      irq_o <= ovf_o && ctrl_q.ien;
      if (wr_reload) reload_q <= wdata;
      if (wr_ctrl) begin
        ctrl_q.start <= wdata[7];
        ctrl_q.ien   <= wdata[6];
        ctrl_q.casc  <= wdata[2];
        ctrl_q.psel  <= wdata[1:0];
      end
      if (start_edge || ovf_o) cnt_q <= reload_q;
      else if (inc)            cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign cnt_o    = cnt_q;
  assign reload_o = reload_q;
  assign ctrl_o   = ctrl_q;
endmodule

// File: rtl/chain_timer_bank.sv
`timescale 1ns/1ps
module chain_timer_bank
  import tmr_pkg::*;
#(
  parameter int NUM_TMR = 4,
  parameter int CNT_W   = 16,
  localparam int SEL_W  = $clog2(NUM_TMR)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               bus_wr,
  input  logic [SEL_W:0]     bus_addr,
  input  logic [CNT_W-1:0]   bus_wdata,
  input  logic [SEL_W-1:0]   rd_sel,
  output logic [2*CNT_W-1:0] rd_data,
  output logic [NUM_TMR-1:0] irq
);
  logic [NUM_TMR-1:0][CNT_W-1:0] cnt_a, reload_a;
  tmr_ctrl_t                     ctrl_a [NUM_TMR];
  logic [NUM_TMR-1:0]            ovf_v, start_v, casc_v, ien_v;

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
    logic sel, chain;
    assign sel = bus_wr && (bus_addr[SEL_W:1] == SEL_W'(g));
    if (g == 0) begin : g_first
      assign chain = 1'b0;
    end else begin : g_next
      assign chain = ovf_v[g-1];
    end

    tmr_channel #(.CNT_W(CNT_W)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .wr_reload(sel && !bus_addr[0]),
      .wr_ctrl  (sel && bus_addr[0]),
      .wdata    (bus_wdata),
      .chain_in (chain),
      .cnt_o    (cnt_a[g]),
      .reload_o (reload_a[g]),
      .ctrl_o   (ctrl_a[g]),
      .ovf_o    (ovf_v[g]),
      .irq_o    (irq[g])
    );

    assign start_v[g] = ctrl_a[g].start;
    assign casc_v[g]  = ctrl_a[g].casc;
    assign ien_v[g]   = ctrl_a[g].ien;
  end

  tmr_ctrl_t rd_ctrl;
  assign rd_ctrl = ctrl_a[rd_sel];
  assign rd_data = {CNT_W'({rd_ctrl.start, rd_ctrl.ien, 3'b000, rd_ctrl.casc, rd_ctrl.psel}),
                    cnt_a[rd_sel]};
endmodule

// File: rtl/tmr_bank_chk.sv
`timescale 1ns/1ps
module tmr_bank_chk #(
  parameter int NUM_TMR = 4,
  parameter int CNT_W   = 16
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [NUM_TMR-1:0]            start,
  input logic [NUM_TMR-1:0]            casc,
  input logic [NUM_TMR-1:0]            ien,
  input logic [NUM_TMR-1:0]            ovf,
  input logic [NUM_TMR-1:0]            irq,
  input logic [NUM_TMR-1:0][CNT_W-1:0] cnt,
  input logic [NUM_TMR-1:0][CNT_W-1:0] reload
);
  for (genvar i = 0; i < NUM_TMR; i++) begin : g_chk
    // R4
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !start[i] |=> (start[i] || $stable(cnt[i])));
    // R7
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq[i] |-> $past(ien[i]));
    // R7
    ovf_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf[i] && ien[i]) |=> irq[i]);
    // R6
    wrap_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq[i] |-> (cnt[i] == $past(reload[i])));
    if (i == 0) begin : g_head
      // R10
      head_casc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start[0] && casc[0]) |=> $stable(cnt[0]));
    end else begin : g_link
      // R8
      casc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start[i] && casc[i] && !ovf[i-1]) |=> $stable(cnt[i]));
    end
  end
endmodule

bind chain_timer_bank tmr_bank_chk #(.NUM_TMR(NUM_TMR), .CNT_W(CNT_W)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .start (start_v),
  .casc  (casc_v),
  .ien   (ien_v),
  .ovf   (ovf_v),
  .irq   (irq),
  .cnt   (cnt_a),
  .reload(reload_a)
);

// File: tb/test_chain_timer_bank.sv
`timescale 1ns/1ps
module test_chain_timer_bank;
  logic        clk = 0, rst_n = 0, tick = 0, bus_wr = 0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [1:0]  rd_sel = '0;
  logic [31:0] rd_data;
  logic [3:0]  irq;
  int errors = 0, total = 0;

  chain_timer_bank i_chain_timer_bank (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; tick = 0; bus_wr = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  task automatic wr(input int t, input bit ctl, input logic [15:0] d);
    bus_wr = 1; bus_addr = {2'(t), ctl}; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input int t, output logic [31:0] v);
    rd_sel = 2'(t); #1; v = rd_data;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      tick = 1; @(negedge clk); tick = 0;
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int t = 0; t < 4; t++) begin rd(t, v); chk("R1 word", v, 32'h0); end
    chk("R1 irq", {28'h0, irq}, 32'h0);
  endtask

  task automatic t_start();
    logic [31:0] v;
    wr(0, 0, 16'h1234); wr(0, 1, 16'h0080);
    rd(0, v); chk("R3 start load / R2 format", v, 32'h0080_1234);
    wr(0, 0, 16'h5555);
    rd(0, v); chk("R11 reload write", v, 32'h0080_1234);
    ticks(3); rd(0, v); chk("R5 div1", v, 32'h0080_1237);
    repeat (4) @(negedge clk);
    rd(0, v); chk("R5 no tick no count", v, 32'h0080_1237);
    wr(0, 1, 16'h0080); rd(0, v); chk("R3 no reload on held start", v, 32'h0080_1237);
    wr(0, 1, 16'h0000); ticks(5); rd(0, v); chk("R4 halted", v, 32'h0000_1237);
    wr(0, 1, 16'h0080); rd(0, v); chk("R3 restart load", v, 32'h0080_5555);
    wr(2, 1, 16'hFFFF); rd(2, v); chk("R2 ctrl mask", v[31:16], 32'h00C7);
  endtask

  task automatic t_prescale();
    logic [31:0] v;
    wr(1, 1, 16'h0081);
    ticks(63); rd(1, v); chk("R5 div64 before", v[15:0], 32'h0);
    ticks(1);  rd(1, v); chk("R5 div64 first", v[15:0], 32'h1);
    ticks(64); rd(1, v); chk("R5 div64 second", v[15:0], 32'h2);
    wr(1, 1, 16'h0000); wr(1, 1, 16'h0082);
    ticks(255); rd(1, v); chk("R5 div256 before", v[15:0], 32'h0);
    ticks(1);   rd(1, v); chk("R5 div256 first", v[15:0], 32'h1);
    wr(1, 1, 16'h0000); wr(1, 1, 16'h0083);
    ticks(1023); rd(1, v); chk("R5 div1024 before", v[15:0], 32'h0);
    ticks(1);    rd(1, v); chk("R5 div1024 first", v[15:0], 32'h1);
  endtask

  task automatic t_overflow();
    logic [31:0] v;
    wr(1, 0, 16'hFFFE); wr(1, 1, 16'h00C0);
    ticks(1); rd(1, v); chk("R6 at max", v[15:0], 32'hFFFF);
    chk("R7 no early irq", {28'h0, irq}, 32'h0);
    ticks(1); rd(1, v); chk("R6 wrap reload", v[15:0], 32'hFFFE);
    chk("R7 irq pulse", {28'h0, irq}, 32'h2);
    @(negedge clk); chk("R7 pulse one cycle", {28'h0, irq}, 32'h0);
    wr(1, 1, 16'h0080);
    tick = 1; @(negedge clk); tick = 1; @(negedge clk); tick = 0;
    rd(1, v); chk("R6 wrap again", v[15:0], 32'hFFFE);
    chk("R7 masked irq", {28'h0, irq}, 32'h0);
  endtask

  task automatic t_cascade();
    logic [31:0] v;
    wr(0, 0, 16'h0000); wr(0, 1, 16'h0080);
    wr(1, 0, 16'hFFFF); wr(1, 1, 16'h00C4);
    wr(2, 0, 16'h0010); wr(2, 1, 16'h0084);
    wr(3, 0, 16'h7777); wr(3, 1, 16'h0004);
    ticks(2);
    rd(0, v); chk("R8 base counts", v[15:0], 32'h2);
    rd(1, v); chk("R8 chain ignores tick", v[15:0], 32'hFFFF);
    wr(0, 1, 16'h0000); wr(0, 0, 16'hFFFF); wr(0, 1, 16'h0080);
    ticks(1);
    chk("R9 irq from chained", {28'h0, irq}, 32'h2);
    rd(0, v); chk("R9 t0 wrap", v[15:0], 32'hFFFF);
    rd(1, v); chk("R9 t1 same cycle", v[15:0], 32'hFFFF);
    rd(2, v); chk("R9 t2 same cycle", v[15:0], 32'h0011);
    rd(3, v); chk("R9 t3 needs start", v[15:0], 32'h0000);
  endtask

  task automatic t_ends();
    logic [31:0] v;
    wr(0, 0, 16'h0042); wr(0, 1, 16'h0084);
    wr(3, 0, 16'hFFFF); wr(3, 1, 16'h0080);
    ticks(4);
    rd(3, v); chk("R10 t3 wraps", v[15:0], 32'hFFFF);
    rd(0, v); chk("R10 t0 chain never counts", v[15:0], 32'h0042);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; total++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, total);
    $finish;
  end

  initial begin
    do_reset(); t_reset();
    t_start();
    do_reset(); t_prescale();
    do_reset(); t_overflow();
    do_reset(); t_cascade();
    do_reset(); t_ends();
    $display("Result: errors=%0d of %0d checks", errors, total);
    $finish;
  end
endmodule